// File: doc/BRIEF.md
# Four-Way Set-Associative Read Cache

This block is a read-only cache that sits between a requester and a slower next-level memory. It holds 1024 one-word (32-bit) blocks as 256 sets of four ways and takes a 32-bit byte address. On each request it compares all four tags of the indexed set at once. On a hit it returns the word in the same cycle. On a miss it asks the next level for the word, writes the word into a victim way, and passes it straight through to the requester.

Requests and responses use valid/ready. Back-pressure works as follows:
- `req_ready` is high only while no miss is outstanding and the consumer asserts `rsp_ready`. A hit is therefore always transferred in the same cycle as the request that caused it.
- The upstream source must hold `req_valid` and `req_addr` stable until `req_ready` is seen.
- The fill side is also valid/ready. `fill_ready` follows `rsp_ready` during a miss, so a returned word is never written unless it can also be delivered.

Victim selection has two rules:
- Empty ways are filled first.
- In a full set, the choice comes from a free-running pseudo-random source, and the way used most recently in that set is never chosen.

Top module: `sa_read_cache`

## Requirements
- R1: Address bits [1:0] are a byte offset and have no effect. Addresses that differ only there hit the same line and return the same word.
- R2: Address bits [9:2] select one of 256 sets. Lines in different sets never displace each other.
- R3: Address bits [31:10] form a 22-bit tag kept per way. A request whose index matches a resident line but whose tag differs is a miss.
- R4: Hit is the OR over the four ways of (valid AND tag equal). On a hit, `rsp_valid`, `rsp_hit` and the matching way's word appear on `rsp_data` in the same cycle as the request.
- R5: At most one way of a set ever matches a given tag.
- R6: A miss accepted on a clock edge raises `fill_req` from the next cycle. `fill_addr` is the request address with bits [1:0] zero, and it is held stable until the fill transfer.
- R7: On the fill transfer (`fill_valid` and `fill_ready`) the word is written into the cache. In that same cycle it is returned with `rsp_valid`=1, `rsp_hit`=0 and `rsp_data`=`fill_data`. `fill_req` drops on the next cycle.
- R8: While a set has an invalid way, a fill goes to its lowest-numbered invalid way. Four distinct tags therefore fill a set without loss.
- R9: Each set keeps a 2-bit most-recently-used way, updated on every hit and fill. In a full set the victim is an LFSR-picked way, advanced by one if it equals that MRU way. As a result, the line touched last before a miss always survives the fill.
- R10: `req_ready` is low while a fill is outstanding or `rsp_ready` is low. With `rsp_ready` low, `fill_ready` is low and the fill stays pending.
- R11: Reset clears every valid bit and returns the block to accepting requests with `fill_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted this cycle |
| req_addr | input | 32 | Byte address of the lookup |
| rsp_valid | output | 1 | Response word valid |
| rsp_ready | input | 1 | Consumer can take a response |
| rsp_hit | output | 1 | Response came from the cache (1) or from a fill (0) |
| rsp_data | output | 32 | Response word |
| fill_req | output | 1 | Next-level read request valid |
| fill_addr | output | 32 | Word-aligned address of the missing block |
| fill_valid | input | 1 | Next-level word valid |
| fill_ready | output | 1 | Fill word can be taken this cycle |
| fill_data | input | 32 | Word returned by the next level |

## Verification
A table of lookups first fills one set with four tags, then hits each of them with varied offset bits. This separates correct set-way storage from offset-sensitive or single-way behaviour. Further vectors place the same tag in two sets and two tags at the top set. These tell index decoding apart from tag comparison.

A repeated pattern of "touch one line, then miss on a new tag" in a full set exercises the pseudo-random victim choice across many LFSR states. The touched line must survive every round. Directed sequences hold `rsp_ready` low during a lookup and during a fill, and apply reset after lines are resident, to separate stalling and clearing from normal flow.

// File: rtl/sarc_pkg.sv
package sarc_pkg;
  typedef enum logic {
    ST_LOOKUP = 1'b0,
    ST_FILL   = 1'b1
  } sarc_state_e;
endpackage

// File: rtl/sarc_tag_store.sv
module sarc_tag_store #(
  parameter int TAG_W   = 22,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 8,
  parameter int WAYS    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [INDEX_W-1:0]        rd_idx,
  output logic [WAYS-1:0]           rd_vld,
  output logic [WAYS*TAG_W-1:0]     rd_tags,
  output logic [WAYS*DATA_W-1:0]    rd_data,
  input  logic                      wr_en,
  input  logic [INDEX_W-1:0]        wr_idx,
  input  logic [$clog2(WAYS)-1:0]   wr_way,
  input  logic [TAG_W-1:0]          wr_tag,
  input  logic [DATA_W-1:0]         wr_data
);
  localparam int SETS = 1 << INDEX_W;

  logic [WAYS-1:0]   vld_q [SETS];
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [DATA_W-1:0] dat_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx][wr_way] <= wr_tag;
      dat_q[wr_idx][wr_way] <= wr_data;
    end
  end

  assign rd_vld = vld_q[rd_idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_tags[w*TAG_W +: TAG_W]   = tag_q[rd_idx][w];
    assign rd_data[w*DATA_W +: DATA_W] = dat_q[rd_idx][w];
  end

  // R7: a written way reads back as valid on the following cycle
  p_write_sets_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)][$past(wr_way)]);
endmodule

// File: rtl/sarc_way_match.sv
module sarc_way_match #(
  parameter int TAG_W  = 22,
  parameter int DATA_W = 32,
  parameter int WAYS   = 4
) (
  input  logic [WAYS-1:0]        set_vld,
  input  logic [WAYS*TAG_W-1:0]  set_tags,
  input  logic [WAYS*DATA_W-1:0] set_data,
  input  logic [TAG_W-1:0]       tag,
  output logic                   hit,
  output logic [WAYS-1:0]        hit_oh,
  output logic [DATA_W-1:0]      hit_data
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_oh[w] = set_vld[w] && (set_tags[w*TAG_W +: TAG_W] == tag);
  end

  assign hit = |hit_oh;

  always_comb begin
    hit_data = '0;
    for (int w = 0; w < WAYS; w++)
      hit_data = hit_data | ({DATA_W{hit_oh[w]}} & set_data[w*DATA_W +: DATA_W]);
  end
endmodule

// File: rtl/sarc_victim.sv
module sarc_victim #(
  parameter int               INDEX_W   = 8,
  parameter int               WAYS      = 4,
  parameter int               LFSR_W    = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [INDEX_W-1:0]        idx,
  input  logic [WAYS-1:0]           set_vld,
  input  logic                      upd_en,
  input  logic [$clog2(WAYS)-1:0]   upd_way,
  output logic [$clog2(WAYS)-1:0]   victim
);
  localparam int SETS  = 1 << INDEX_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [WAY_W-1:0]  mru_q [SETS];
  logic [LFSR_W-1:0] lfsr_q;
  logic [WAY_W-1:0]  first_free, rnd;
  logic              any_free;

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr_q <= LFSR_W'(1);
    else        lfsr_q <= lfsr_q[0] ? ((lfsr_q >> 1) ^ LFSR_TAPS) : (lfsr_q >> 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) mru_q[s] <= '0;
    end else if (upd_en) begin
      mru_q[idx] <= upd_way;
    end
  end

  always_comb begin
    first_free = '0;
    any_free   = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!set_vld[w]) begin
        first_free = WAY_W'(w);
        any_free   = 1'b1;
      end
    end
    rnd = lfsr_q[WAY_W-1:0];
    if (any_free)              victim = first_free;
    else if (rnd == mru_q[idx]) victim = rnd + WAY_W'(1);
    else                       victim = rnd;
  end

  // R8: with an empty way present, the victim is an empty way
  p_free_way_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(&set_vld) |-> !set_vld[victim]);
  // R9: in a full set, the most recently used way is never the victim
  p_victim_not_mru_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&set_vld) |-> (victim != mru_q[idx]));
endmodule

// File: rtl/sa_read_cache.sv
module sa_read_cache #(
  parameter int               ADDR_W    = 32,
  parameter int               DATA_W    = 32,
  parameter int               OFFS_W    = 2,
  parameter int               INDEX_W   = 8,
  parameter int               WAYS      = 4,
  parameter int               LFSR_W    = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [DATA_W-1:0] fill_data
);
  import sarc_pkg::*;

  localparam int TAG_W  = ADDR_W - INDEX_W - OFFS_W;
  localparam int LINE_W = ADDR_W - OFFS_W;
  localparam int WAY_W  = $clog2(WAYS);

  sarc_state_e       state_q;
  logic [LINE_W-1:0] pend_line_q;

  logic [INDEX_W-1:0]     req_idx, pend_idx, rd_idx;
  logic [TAG_W-1:0]       req_tag, pend_tag;
  logic                   in_fill, req_fire, fill_fire;
  logic [WAYS-1:0]        set_vld, hit_oh;
  logic [WAYS*TAG_W-1:0]  set_tags;
  logic [WAYS*DATA_W-1:0] set_data;
  logic                   hit;
  logic [DATA_W-1:0]      hit_data;
  logic [WAY_W-1:0]       hit_way, victim, upd_way;
  logic                   upd_en;

  assign req_idx  = req_addr[OFFS_W +: INDEX_W];
  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign pend_idx = pend_line_q[INDEX_W-1:0];
  assign pend_tag = pend_line_q[LINE_W-1 -: TAG_W];

  assign in_fill   = (state_q == ST_FILL);
  assign rd_idx    = in_fill ? pend_idx : req_idx;
  assign req_ready = !in_fill && rsp_ready;
  assign req_fire  = req_valid && req_ready;
  assign fill_ready = in_fill && rsp_ready;
  assign fill_fire = fill_valid && fill_ready;
  assign fill_req  = in_fill;
  assign fill_addr = {pend_line_q, {OFFS_W{1'b0}}};

  assign rsp_valid = in_fill ? fill_valid : (req_valid && hit);
  assign rsp_hit   = !in_fill && hit;
  assign rsp_data  = in_fill ? fill_data : hit_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_LOOKUP;
      pend_line_q <= '0;
    end else begin
      unique case (state_q)
        ST_LOOKUP: if (req_fire && !hit) begin
          state_q     <= ST_FILL;
          pend_line_q <= req_addr[ADDR_W-1:OFFS_W];
        end
        ST_FILL: if (fill_fire) state_q <= ST_LOOKUP;
        default: state_q <= ST_LOOKUP;
      endcase
    end
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_oh[w]) hit_way = WAY_W'(w);
  end

  assign upd_en  = (req_fire && hit) || fill_fire;
  assign upd_way = in_fill ? victim : hit_way;

  sarc_tag_store #(
    .TAG_W(TAG_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W), .WAYS(WAYS)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_vld(set_vld), .rd_tags(set_tags), .rd_data(set_data),
    .wr_en(fill_fire), .wr_idx(pend_idx), .wr_way(victim),
    .wr_tag(pend_tag), .wr_data(fill_data)
  );

  sarc_way_match #(
    .TAG_W(TAG_W), .DATA_W(DATA_W), .WAYS(WAYS)
  ) u_match (
    .set_vld(set_vld), .set_tags(set_tags), .set_data(set_data), .tag(req_tag),
    .hit(hit), .hit_oh(hit_oh), .hit_data(hit_data)
  );

  sarc_victim #(
    .INDEX_W(INDEX_W), .WAYS(WAYS), .LFSR_W(LFSR_W), .LFSR_TAPS(LFSR_TAPS)
  ) u_victim (
    .clk(clk), .rst_n(rst_n), .idx(rd_idx), .set_vld(set_vld),
    .upd_en(upd_en), .upd_way(upd_way), .victim(victim)
  );

  // R5: no tag is ever resident in two ways of one set
  p_one_way_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_oh));
  // R6: an accepted miss starts a fill on the next cycle
  p_miss_starts_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !rsp_hit) |=> fill_req);
  // R6: a pending fill keeps its address until transferred
  p_fill_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !(fill_valid && fill_ready)) |=> (fill_req && $stable(fill_addr)));
  // R7: a transferred fill word is returned as a non-hit response, then the fill ends
  p_fill_returns_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |-> (rsp_valid && !rsp_hit && rsp_data == fill_data));
  p_fill_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=> !fill_req);
  // R10: no new request is taken while a fill is outstanding
  p_no_accept_in_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !req_ready);
endmodule

// File: tb/sa_read_cache_test.sv
module sa_read_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit;
  logic [31:0] rsp_data;
  logic        fill_req;
  logic [31:0] fill_addr;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [31:0] fill_data = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  sa_read_cache uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_valid(fill_valid),
    .fill_ready(fill_ready), .fill_data(fill_data)
  );

  // bit 32 = expected hit, bits 31:0 = byte address
  localparam logic [32:0] VEC [18] = '{
    {1'b0, 32'h0000_1000}, {1'b1, 32'h0000_1000}, {1'b1, 32'h0000_1003},
    {1'b0, 32'h0000_2000}, {1'b0, 32'h0000_3000}, {1'b0, 32'h0000_4000},
    {1'b1, 32'h0000_1000}, {1'b1, 32'h0000_2001}, {1'b1, 32'h0000_3000},
    {1'b1, 32'h0000_4002}, {1'b0, 32'h0000_1004}, {1'b1, 32'h0000_1004},
    {1'b1, 32'h0000_1006}, {1'b0, 32'hFFFF_FFFC}, {1'b1, 32'hFFFF_FFFD},
    {1'b0, 32'h0000_03FC}, {1'b1, 32'hFFFF_FFFE}, {1'b1, 32'h0000_03FF}
  };

  function automatic string vec_req(input int i);
    case (i)
      2, 7, 12, 14, 16, 17: return "R1";
      10, 11:               return "R2";
      15:                   return "R3";
      6, 8, 9:              return "R8";
      0, 3, 4, 5, 13:       return "R6";
      default:              return "R4";
    endcase
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_C3C3;
  endfunction

  function automatic logic [31:0] set7(input int tag);
    return (32'(tag) << 10) | 32'h1C;
  endfunction

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // One lookup; on a miss, serves the fill after fill_delay idle cycles
  task automatic access(input logic [31:0] a, input int fill_delay,
                        output logic got_hit, output logic [31:0] got_data);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    rsp_ready = 1'b1;
    #1;
    got_hit  = rsp_valid && rsp_hit;
    got_data = rsp_data;
    @(negedge clk);
    req_valid = 1'b0;
    if (!got_hit) begin
      #1;
      check(fill_req == 1'b1, "R6 fill_req after miss", 32'(fill_req), 32'd1);
      check(fill_addr == {a[31:2], 2'b00}, "R6 fill_addr", fill_addr, {a[31:2], 2'b00});
      check(req_ready == 1'b0, "R10 req_ready during fill", 32'(req_ready), 32'd0);
      repeat (fill_delay) @(negedge clk);
      fill_valid = 1'b1;
      fill_data  = mem_word(fill_addr);
      #1;
      check(rsp_valid && !rsp_hit, "R7 fill response flags",
            {30'd0, rsp_valid, rsp_hit}, 32'd2);
      got_data = rsp_data;
      @(negedge clk);
      fill_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic        h;
    logic [31:0] d;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    check(req_ready == 1'b1, "R11 req_ready after reset", 32'(req_ready), 32'd1);
    check(fill_req == 1'b0, "R11 fill_req after reset", 32'(fill_req), 32'd0);
    check(rsp_valid == 1'b0, "R11 rsp_valid idle", 32'(rsp_valid), 32'd0);

    // Table walk: R1 offsets, R2 sets, R3 tags, R4 hit data, R5/R8 set fill
    for (int i = 0; i < 18; i++) begin
      access(VEC[i][31:0], i % 3, h, d);
      check(h == VEC[i][32], {vec_req(i), " hit flag"}, 32'(h), 32'(VEC[i][32]));
      check(d == mem_word(VEC[i][31:0]), {vec_req(i), " data"}, d, mem_word(VEC[i][31:0]));
    end

    // R10: rsp_ready low blocks acceptance of a resident-line request
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1;
    req_addr  = 32'h0000_1000;
    #1;
    check(req_ready == 1'b0, "R10 req_ready with rsp_ready low", 32'(req_ready), 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    rsp_ready = 1'b1;

    // R10: fill stalled by rsp_ready low
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 32'h0000_5010;
    @(negedge clk);
    req_valid  = 1'b0;
    rsp_ready  = 1'b0;
    fill_valid = 1'b1;
    fill_data  = mem_word(32'h0000_5010);
    #1;
    check(fill_ready == 1'b0, "R10 fill_ready with rsp_ready low", 32'(fill_ready), 32'd0);
    @(negedge clk);
    #1;
    check(fill_req == 1'b1, "R10 fill still pending", 32'(fill_req), 32'd1);
    rsp_ready = 1'b1;
    #1;
    check(rsp_valid && rsp_data == mem_word(32'h0000_5010), "R7 stalled fill data",
          rsp_data, mem_word(32'h0000_5010));
    @(negedge clk);
    fill_valid = 1'b0;
    #1;
    check(fill_req == 1'b0, "R7 fill_req drops", 32'(fill_req), 32'd0);
    access(32'h0000_5010, 0, h, d);
    check(h == 1'b1, "R7 filled word now hits", 32'(h), 32'd1);

    // R9: keeper line touched before every miss must survive
    for (int t = 1; t <= 4; t++) access(set7(t), 1, h, d);
    for (int r = 0; r < 12; r++) begin
      access(set7(1), 0, h, d);
      check(h == 1'b1, "R9 keeper hit before miss", 32'(h), 32'd1);
      access(set7(100 + r), r % 2, h, d);
      check(h == 1'b0, "R9 new tag misses", 32'(h), 32'd0);
      access(set7(1), 0, h, d);
      check(h == 1'b1 && d == mem_word(set7(1)), "R9 keeper survives fill", d, mem_word(set7(1)));
      access(set7(100 + r), 0, h, d);
      check(h == 1'b1, "R9 new line resident", 32'(h), 32'd1);
    end

    // R11: reset mid-run clears resident lines
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    access(32'h0000_1000, 0, h, d);
    check(h == 1'b0, "R11 line lost after reset", 32'(h), 32'd1 ^ 32'd1);
    check(d == mem_word(32'h0000_1000), "R11 refill data", d, mem_word(32'h0000_1000));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule